// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of page table out of a word-addressed memory. A request carries the virtual address, a read/write flag and the base address of the current process's top-level table. The walker reads the directory entry and then the leaf entry. It either returns the translated address or reports a fault. When it succeeds, it updates the leaf's reference and modified flags in memory.

Only one walk is in flight at a time. A request is taken only while the walker is idle. Every memory access uses a valid/ready request channel, and a read's data comes back on a separate one-cycle response strobe after a variable delay. The result appears as a single-cycle pulse that carries the physical address and a fault code.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0. `req_ready` is 1 only while idle, so it stays 0 from the cycle after a request is accepted until the result pulse has ended.
- R2: The first memory read goes to `req_base + VA[31:22]*4`.
- R3: When the directory entry is valid, the second read goes to `{entry[31:12], 12'h000} + VA[21:12]*4`.
- R4: A directory entry with bit 0 (valid) clear ends the walk with fault code 1 (page fault). There is no second read and no memory write.
- R5: A leaf entry with bit 0 clear ends the walk with fault code 1 and no memory write.
- R6: A write request whose valid leaf has bit 1 (writable) clear ends with fault code 2 (protection fault) and no memory write. Reads ignore bit 1.
- R7: A successful walk returns fault code 0 and `rsp_paddr = {leaf[31:12], VA[11:0]}`. On any fault, `rsp_paddr` is 0.
- R8: A successful walk writes the leaf back to its own address. The written word has bit 2 (used) set, has bit 3 (dirty) set when the request was a write, and keeps every other bit.
- R9: When the leaf already carries the bits that R8 would set, no memory write is issued.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request's valid, address, write flag and data hold steady into the next cycle.
- R11: Each accepted request yields exactly one `rsp_valid` pulse, one cycle long, and the walker is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = store access, 0 = load access |
| req_base | input | 32 | Byte address of the process's directory table |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Entry value for writes |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |

## Verification
Two things are hard to reach from the ports: a memory write that is stalled for several cycles, and a read response that comes late after a stalled request. The bench's memory model withholds ready at random and delays each response by a random number of cycles, so stalls of varying length occur on both reads and the status write-back. The bench also reuses leaf entries across random walks, so a later walk often finds the used or dirty flag already set by an earlier one. That exercises the case where the write is skipped without any special setup.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    parameter int VA_W   = 32;
    parameter int PA_W   = 32;
    parameter int OFF_W  = 12;
    parameter int IDX_W  = 10;
    parameter int ENT_W  = 32;

    localparam int FRAME_W   = ENT_W - OFF_W;
    localparam int ENT_SHIFT = $clog2(ENT_W / 8);
    localparam int RSVD_W    = ENT_W - FRAME_W - 4;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_L1   = 3'd1,
        ST_L2   = 3'd2,
        ST_UPD  = 3'd3,
        ST_DONE = 3'd4
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } fault_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [RSVD_W-1:0]  rsvd;
        logic               dirty;
        logic               used;
        logic               writable;
        logic               valid;
    } pte_t;

    function automatic logic [IDX_W-1:0] dir_index(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] tbl_index(input logic [VA_W-1:0] va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] tbl,
                                                   input logic [IDX_W-1:0] idx);
        return tbl + (PA_W'(idx) << ENT_SHIFT);
    endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  walk_state_e        state,
    input  logic [PA_W-1:0]    dir_base,
    input  logic [PA_W-1:0]    tbl_base,
    input  logic [IDX_W-1:0]   dir_idx,
    input  logic [IDX_W-1:0]   tbl_idx,
    output logic [PA_W-1:0]    rd_addr
);
    logic [PA_W-1:0]  sel_base;
    logic [IDX_W-1:0] sel_idx;

    always_comb begin
        if (state == ST_L2) begin
            sel_base = tbl_base;
            sel_idx  = tbl_idx;
        end else begin
            sel_base = dir_base;
            sel_idx  = dir_idx;
        end
        rd_addr = entry_addr(sel_base, sel_idx);
    end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
(
    input  pte_t   entry,
    input  logic   is_leaf,
    input  logic   is_write,
    output fault_e fault,
    output pte_t   next_entry,
    output logic   need_wb
);
    always_comb begin
        fault      = FLT_NONE;
        next_entry = entry;
        need_wb    = 1'b0;
        if (!entry.valid) begin
            fault = FLT_PAGE;
        end else if (is_leaf) begin
            if (is_write && !entry.writable) begin
                fault = FLT_PROT;
            end else begin
                next_entry.used = 1'b1;
                if (is_write) next_entry.dirty = 1'b1;
                need_wb = (next_entry != entry);
            end
        end
    end
endmodule

// File: rtl/ptw_mem_port.sv
module ptw_mem_port
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_active,
    input  logic              op_write,
    input  logic [PA_W-1:0]   op_addr,
    input  logic [ENT_W-1:0]  op_wdata,
    output logic              op_done,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic [ENT_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid
);
    logic issued_q;

    assign mem_req_valid = op_active && !issued_q;
    assign mem_req_write = op_write;
    assign mem_req_addr  = op_addr;
    assign mem_req_wdata = op_wdata;

    always_comb begin
        if (op_write) op_done = mem_req_valid && mem_req_ready;
        else          op_done = issued_q && mem_rsp_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            issued_q <= 1'b0;
        end else if (issued_q && mem_rsp_valid) begin
            issued_q <= 1'b0;
        end else if (mem_req_valid && mem_req_ready && !op_write) begin
            issued_q <= 1'b1;
        end
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic              req_write,
    input  logic [31:0]       req_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [31:0]       mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              rsp_valid,
    output logic [31:0]       rsp_paddr,
    output logic [1:0]        rsp_fault
);
    walk_state_e       state_q;
    logic [VA_W-1:0]   vaddr_q;
    logic              wr_q;
    logic [PA_W-1:0]   dir_base_q;
    logic [PA_W-1:0]   tbl_base_q;
    logic [PA_W-1:0]   leaf_addr_q;
    pte_t              leaf_q;
    pte_t              wb_q;
    fault_e            fault_q;

    logic [PA_W-1:0]   rd_addr;
    logic              op_active;
    logic              op_write;
    logic [PA_W-1:0]   op_addr;
    logic              op_done;
    pte_t              rsp_entry;
    fault_e            eval_fault;
    pte_t              eval_next;
    logic              eval_wb;

    assign rsp_entry = pte_t'(mem_rsp_data);

    ptw_addr_gen u_addr (
        .state    (state_q),
        .dir_base (dir_base_q),
        .tbl_base (tbl_base_q),
        .dir_idx  (dir_index(vaddr_q)),
        .tbl_idx  (tbl_index(vaddr_q)),
        .rd_addr  (rd_addr)
    );

    ptw_pte_eval u_eval (
        .entry      (rsp_entry),
        .is_leaf    (state_q == ST_L2),
        .is_write   (wr_q),
        .fault      (eval_fault),
        .next_entry (eval_next),
        .need_wb    (eval_wb)
    );

    always_comb begin
        op_active = (state_q == ST_L1) || (state_q == ST_L2) || (state_q == ST_UPD);
        op_write  = (state_q == ST_UPD);
        op_addr   = op_write ? leaf_addr_q : rd_addr;
    end

    ptw_mem_port u_port (
        .clk           (clk),
        .rst           (rst),
        .op_active     (op_active),
        .op_write      (op_write),
        .op_addr       (op_addr),
        .op_wdata      (wb_q),
        .op_done       (op_done),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            vaddr_q     <= '0;
            wr_q        <= 1'b0;
            dir_base_q  <= '0;
            tbl_base_q  <= '0;
            leaf_addr_q <= '0;
            leaf_q      <= '0;
            wb_q        <= '0;
            fault_q     <= FLT_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q    <= req_vaddr;
                        wr_q       <= req_write;
                        dir_base_q <= req_base;
                        fault_q    <= FLT_NONE;
                        state_q    <= ST_L1;
                    end
                end
                ST_L1: begin
                    if (op_done) begin
                        if (eval_fault != FLT_NONE) begin
                            fault_q <= eval_fault;
                            state_q <= ST_DONE;
                        end else begin
                            tbl_base_q <= {rsp_entry.frame, {OFF_W{1'b0}}};
                            state_q    <= ST_L2;
                        end
                    end
                end
                ST_L2: begin
                    if (op_done) begin
                        leaf_q      <= rsp_entry;
                        leaf_addr_q <= rd_addr;
                        wb_q        <= eval_next;
                        fault_q     <= eval_fault;
                        if (eval_fault == FLT_NONE && eval_wb) state_q <= ST_UPD;
                        else                                   state_q <= ST_DONE;
                    end
                end
                ST_UPD: begin
                    if (op_done) state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_DONE);
    assign rsp_fault = fault_q;
    assign rsp_paddr = (fault_q == FLT_NONE) ? {leaf_q.frame, vaddr_q[OFF_W-1:0]} : '0;

    assert_busy_no_accept_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    assert_wb_fields_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |->
            (mem_req_wdata[2] && mem_req_wdata[0] && (mem_req_wdata[3] || !wr_q)));

    assert_fault_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (fault_q == FLT_NONE));

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    assert_fault_zero_addr_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == 32'd0));
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    always #5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_base(req_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] mem [logic [31:0]];
    int          n_rd = 0;
    int          n_wr = 0;
    logic [31:0] last_waddr = '0;
    logic [31:0] last_wdata = '0;
    logic        pend = 1'b0;
    int          dly = 0;
    logic [31:0] pend_addr = '0;
    logic        hold_chk = 1'b0;
    logic [31:0] hold_addr = '0;
    logic [31:0] hold_data = '0;
    logic        hold_wr = 1'b0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'd0;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model, drives and observes at negedge
    always @(negedge clk) begin
        if (rst) begin
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            pend = 1'b0;
            hold_chk = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(pend_addr);
                    pend = 1'b0;
                end else begin
                    dly--;
                end
            end
            if (hold_chk) begin
                check(mem_req_valid && mem_req_addr == hold_addr &&
                      mem_req_wdata == hold_data && mem_req_write == hold_wr,
                      "R10 request held", mem_req_addr, hold_addr);
            end
            mem_req_ready = ($urandom % 2) == 0;
            hold_chk  = mem_req_valid && !mem_req_ready;
            hold_addr = mem_req_addr;
            hold_data = mem_req_wdata;
            hold_wr   = mem_req_write;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    mem[mem_req_addr] = mem_req_wdata;
                    n_wr++;
                    last_waddr = mem_req_addr;
                    last_wdata = mem_req_wdata;
                end else begin
                    n_rd++;
                    pend = 1'b1;
                    pend_addr = mem_req_addr;
                    dly = $urandom % 4;
                end
            end
        end
    end

    task automatic run_walk(input logic [31:0] va, input logic wr, input logic [31:0] base,
                            input string tag);
        logic [31:0] l1a, l2a, e1, e2, nv, x_paddr, x_waddr, x_wdata;
        logic [1:0]  x_fault;
        int          x_rd, x_wr, rd0, wr0, cyc, pulses;
        logic        busy_ok;
        // expected behaviour from current memory image
        l1a = base + {20'd0, va[31:22], 2'b00};
        e1  = rd(l1a);
        x_rd = 1; x_wr = 0; x_paddr = 0; x_waddr = 0; x_wdata = 0;
        if (!e1[0]) x_fault = 2'd1;
        else begin
            x_rd = 2;
            l2a = {e1[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
            e2  = rd(l2a);
            if (!e2[0]) x_fault = 2'd1;
            else if (wr && !e2[1]) x_fault = 2'd2;
            else begin
                x_fault = 2'd0;
                x_paddr = {e2[31:12], va[11:0]};
                nv = e2 | 32'h4 | (wr ? 32'h8 : 32'h0);
                if (nv != e2) begin x_wr = 1; x_waddr = l2a; x_wdata = nv; end
            end
        end
        rd0 = n_rd; wr0 = n_wr;
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_base = base; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = 1'b1; cyc = 0; pulses = 0;
        while (!rsp_valid && cyc < 200) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        check(busy_ok, {"R1 busy ", tag}, 32'(busy_ok), 32'd1);
        check(rsp_valid, {"R11 result arrives ", tag}, 32'(rsp_valid), 32'd1);
        if (rsp_valid) pulses++;
        check(32'(rsp_fault) == 32'(x_fault), {"R4 R5 R6 fault ", tag},
              32'(rsp_fault), 32'(x_fault));
        check(rsp_paddr == x_paddr, {"R7 paddr ", tag}, rsp_paddr, x_paddr);
        check(n_rd - rd0 == x_rd, {"R2 R3 R4 read count ", tag},
              32'(n_rd - rd0), 32'(x_rd));
        check(n_wr - wr0 == x_wr, {"R8 R9 write count ", tag},
              32'(n_wr - wr0), 32'(x_wr));
        if (x_wr == 1 && n_wr - wr0 == 1) begin
            check(last_waddr == x_waddr, {"R8 write addr ", tag}, last_waddr, x_waddr);
            check(last_wdata == x_wdata, {"R8 write data ", tag}, last_wdata, x_wdata);
        end
        @(negedge clk);
        if (rsp_valid) pulses++;
        check(pulses == 1 && req_ready, {"R11 one pulse ", tag}, 32'(pulses), 32'd1);
    endtask

    localparam logic [31:0] BASE_A = 32'h0001_0000;
    localparam logic [31:0] BASE_B = 32'h0002_0000;

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && !mem_req_valid && !rsp_valid, "R1 reset state",
              {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'h4);
        rst = 1'b0;
        @(negedge clk);

        // directory: idx 1 -> table at 0x0010_0000, idx 0x3FF -> 0x0011_0000, idx 2 invalid
        mem[BASE_A + 32'h4]   = 32'h0010_0001;
        mem[BASE_A + 32'hFFC] = 32'h0011_0001;
        mem[BASE_A + 32'h8]   = 32'h0012_0000;
        mem[BASE_B + 32'h4]   = 32'h0013_0001;
        // leaves
        mem[32'h0010_0000 + 32'h0]  = 32'hABCDE_003;   // R/W, fresh
        mem[32'h0010_0000 + 32'h4]  = 32'h12345_001;   // read only
        mem[32'h0010_0000 + 32'h8]  = 32'h55555_000;   // invalid
        mem[32'h0010_0000 + 32'hC]  = 32'h77777_00F;   // all bits set
        mem[32'h0011_0000 + 32'hFFC]= 32'hFEDCB_003;
        mem[32'h0013_0000 + 32'h0]  = 32'h99999_001;

        run_walk(32'h0080_2000, 1'b0, BASE_A, "R4 dir invalid");
        run_walk(32'h0040_2123, 1'b0, BASE_A, "R5 leaf invalid");
        run_walk(32'h0040_1456, 1'b1, BASE_A, "R6 write read-only");
        run_walk(32'h0040_1456, 1'b0, BASE_A, "R6 read read-only sets used");
        run_walk(32'h0040_1456, 1'b0, BASE_A, "R9 used already set");
        run_walk(32'h0040_0789, 1'b0, BASE_A, "R8 read fresh");
        run_walk(32'h0040_0789, 1'b1, BASE_A, "R8 write sets dirty");
        run_walk(32'h0040_3FFF, 1'b1, BASE_A, "R9 all set write");
        run_walk(32'hFFFF_FFFF, 1'b1, BASE_A, "R2 R3 top indices");
        run_walk(32'h0040_0ABC, 1'b0, BASE_B, "R2 other process base");

        for (int i = 0; i < 300; i++) begin
            logic [31:0] va, base, l1a, l2a, e1;
            logic        wr;
            va   = $urandom & 32'h00C0_3FFF;
            wr   = $urandom % 2;
            base = ($urandom % 2) ? BASE_B : BASE_A;
            l1a  = base + {20'd0, va[31:22], 2'b00};
            if ($urandom % 4 == 0)
                mem[l1a] = {12'h001, 4'($urandom % 4), 4'h0, 11'd0, 1'(($urandom % 8) != 0)};
            e1 = rd(l1a);
            if (e1[0]) begin
                l2a = {e1[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
                if ($urandom % 3 == 0)
                    mem[l2a] = {20'($urandom), 8'h00, 4'($urandom | 32'h1)};
                else if ($urandom % 6 == 0)
                    mem[l2a] = 32'h0;
            end
            run_walk(va, wr, base, "random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule